// File: doc/BRIEF.md
# Program Exception Condition Detector

This block sits next to instruction decode in a simple in-order core. For each decoded instruction it decides whether a program exception is due. It tests three causes side by side: an enabled floating-point condition made visible by a state-changing instruction, a supervisor-only operation attempted at user level, and a trap whose selected comparison holds. It then reports a single vectored request, the cause flags to be saved, and the handler address.

A pending exception of higher priority from elsewhere in the core suppresses the request. A floating-point arithmetic instruction that meets the enabled condition never raises a program exception; it raises a separate assist request instead. All outputs are registered and follow the instruction-valid strobe by one clock.

Top module: `progExcDetect`

## Requirements
- R1: All outputs are zero after reset. The outputs reflect the instruction presented with `instValid` high one clock later. When `instValid` is low, the next cycle shows no request, no assist request and zero cause and vector.
- R2: While `higherPending` is high, the instruction raises neither `excReq` nor `fpAssistReq`, and the cause and vector outputs stay zero.
- R3: The FP-enabled cause (`causeBits[0]`) is set when (`msrFe0` OR `msrFe1`) AND `fpsFex` is 1. This applies only for class 1 (move to FP status), class 2 (move to machine state) and class 4 (return from interrupt). It applies to no other class.
- R4: For class 7 (FP arithmetic), the same enabled condition drives `fpAssistReq` high and never drives `excReq` or `causeBits`.
- R5: The privileged cause (`causeBits[1]`) is set for class 2, class 3 (move from machine state) and class 4 when `msrPr` is 1 (user level). It is clear when `msrPr` is 0.
- R6: For class 5 (move to/from special register) with `sprSuper` = 1 and `msrPr` = 1, the privileged cause is set when `sprExternal` is 1, whatever `sprValid` is. It is also set when the register is internal and `sprValid` is 1.
- R7: For class 5, an internal (`sprExternal` = 0) invalid (`sprValid` = 0) supervisor register at user level does not set the privileged cause. A register with `sprSuper` = 0 never sets it either.
- R8: For class 6 (trap), the trap cause (`causeBits[2]`) is set when any selected comparison of `opA` against `opB` holds. The selections are `trapCond[4]` signed less-than, `[3]` signed greater-than, `[2]` equal, `[1]` unsigned less-than and `[0]` unsigned greater-than.
- R9: While `excReq` is high, `excVector` is 0x00000700 when `msrIp` is 0 and 0xFFF00700 when `msrIp` is 1. It is zero otherwise.
- R10: Causes that coincide are all flagged together. `excReq` is high exactly when at least one cause bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Decoded instruction is present this cycle |
| instClass | input | 3 | Instruction class code (see R3 to R8) |
| sprSuper | input | 1 | Supervisor flag bit of the special-register field |
| sprExternal | input | 1 | Special register lies outside the processor |
| sprValid | input | 1 | Special register encoding is implemented |
| trapCond | input | 5 | Trap comparison select field |
| opA | input | XLEN | First trap operand |
| opB | input | XLEN | Second trap operand |
| msrPr | input | 1 | Privilege bit, 1 = user level |
| msrFe0 | input | 1 | FP exception mode bit 0 |
| msrFe1 | input | 1 | FP exception mode bit 1 |
| msrIp | input | 1 | Vector base select |
| fpsFex | input | 1 | FP status enabled-exception summary |
| higherPending | input | 1 | Higher-priority exception pending |
| excReq | output | 1 | Program exception request |
| causeBits | output | 3 | Saved-status cause flags: [0] FP-enabled, [1] privileged, [2] trap |
| excVector | output | ADDR_W | Handler address |
| fpAssistReq | output | 1 | Floating-point assist request |

## Verification
The bench builds the block with its defaults, XLEN = 32 and ADDR_W = 32. At this width the signed and unsigned trap comparisons disagree on operands whose top bit is set, so directed operand pairs of 0x80000000 against 1 separate the two orderings. The full 32-bit vector base also makes both base addresses observable. Random operands drawn from a small pool make equality and sign-crossing cases frequent.

// File: rtl/progExcPkg.sv
package progExcPkg;

  typedef enum logic [2:0] {
    CLS_OTHER   = 3'd0,
    CLS_MTFPS   = 3'd1,
    CLS_MTSTATE = 3'd2,
    CLS_MFSTATE = 3'd3,
    CLS_RETINT  = 3'd4,
    CLS_SPRMOVE = 3'd5,
    CLS_TRAP    = 3'd6,
    CLS_FPARITH = 3'd7
  } instClassE;

  localparam int CAUSE_W    = 3;
  localparam int CAUSE_FPEN = 0;
  localparam int CAUSE_PRIV = 1;
  localparam int CAUSE_TRAP = 2;
  localparam int TRAP_SEL_W = 5;

  typedef struct packed {
    logic fire;     // instruction valid and not pre-empted
    logic fpCheck;  // state-changing instruction: test enabled FP condition
    logic privOp;   // supervisor-only machine-state operation
    logic sprMove;  // special-register move
    logic trapOp;   // trap instruction
    logic fpArith;  // FP arithmetic instruction
  } ctrlStrobeT;

endpackage

// File: rtl/progExcCtrl.sv
module progExcCtrl
  import progExcPkg::*;
(
  input  logic       instValid,
  input  logic       higherPending,
  input  logic [2:0] instClass,
  output ctrlStrobeT strobes
);

  instClassE cls;

  always_comb begin
    cls = instClassE'(instClass);
    strobes = '0;
    strobes.fire = instValid && !higherPending;
    unique case (cls)
      CLS_MTFPS:   strobes.fpCheck = 1'b1;
      CLS_MTSTATE: begin
        strobes.fpCheck = 1'b1;
        strobes.privOp  = 1'b1;
      end
      CLS_MFSTATE: strobes.privOp = 1'b1;
      CLS_RETINT:  begin
        strobes.fpCheck = 1'b1;
        strobes.privOp  = 1'b1;
      end
      CLS_SPRMOVE: strobes.sprMove = 1'b1;
      CLS_TRAP:    strobes.trapOp  = 1'b1;
      CLS_FPARITH: strobes.fpArith = 1'b1;
      default:     ;
    endcase
  end

endmodule

// File: rtl/progExcDatapath.sv
module progExcDatapath
  import progExcPkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0700,
  parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobeT            strobes,
  input  logic                  sprSuper,
  input  logic                  sprExternal,
  input  logic                  sprValid,
  input  logic [TRAP_SEL_W-1:0] trapCond,
  input  logic [XLEN-1:0]       opA,
  input  logic [XLEN-1:0]       opB,
  input  logic                  msrPr,
  input  logic                  msrFe0,
  input  logic                  msrFe1,
  input  logic                  msrIp,
  input  logic                  fpsFex,
  output logic                  excReq,
  output logic [CAUSE_W-1:0]    causeBits,
  output logic [ADDR_W-1:0]     excVector,
  output logic                  fpAssistReq
);

  localparam logic [ADDR_W-1:0] LOW_VEC  = ADDR_W'(VEC_OFFSET);
  localparam logic [ADDR_W-1:0] HIGH_VEC = ADDR_W'(HIGH_BASE) | ADDR_W'(VEC_OFFSET);

  logic [TRAP_SEL_W-1:0] cmpHit;
  logic                  fpEnabledCond;
  logic                  sprPriv;
  logic [CAUSE_W-1:0]    causeNext;
  logic                  reqNext;
  logic                  assistNext;

  // Comparison bank, ordered to match the select field bit positions
  always_comb begin
    cmpHit[4] = $signed(opA) <  $signed(opB);
    cmpHit[3] = $signed(opA) >  $signed(opB);
    cmpHit[2] = opA == opB;
    cmpHit[1] = opA <  opB;
    cmpHit[0] = opA >  opB;
  end

  always_comb begin
    fpEnabledCond = (msrFe0 | msrFe1) & fpsFex;
    // Invalid internal supervisor registers are left to other handling
    sprPriv = strobes.sprMove & sprSuper & msrPr & (sprExternal | sprValid);
    causeNext = '0;
    causeNext[CAUSE_FPEN] = strobes.fpCheck & fpEnabledCond;
    causeNext[CAUSE_PRIV] = (strobes.privOp & msrPr) | sprPriv;
    causeNext[CAUSE_TRAP] = strobes.trapOp & (|(cmpHit & trapCond));
    if (!strobes.fire) causeNext = '0;
    reqNext    = |causeNext;
    assistNext = strobes.fire & strobes.fpArith & fpEnabledCond;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excReq      <= 1'b0;
      causeBits   <= '0;
      excVector   <= '0;
      fpAssistReq <= 1'b0;
    end else begin
      excReq      <= reqNext;
      causeBits   <= causeNext;
      excVector   <= reqNext ? (msrIp ? HIGH_VEC : LOW_VEC) : '0;
      fpAssistReq <= assistNext;
    end
  end

endmodule

// File: rtl/progExcDetect.sv
module progExcDetect
  import progExcPkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        instClass,
  input  logic              sprSuper,
  input  logic              sprExternal,
  input  logic              sprValid,
  input  logic [4:0]        trapCond,
  input  logic [XLEN-1:0]   opA,
  input  logic [XLEN-1:0]   opB,
  input  logic              msrPr,
  input  logic              msrFe0,
  input  logic              msrFe1,
  input  logic              msrIp,
  input  logic              fpsFex,
  input  logic              higherPending,
  output logic              excReq,
  output logic [2:0]        causeBits,
  output logic [ADDR_W-1:0] excVector,
  output logic              fpAssistReq
);

  ctrlStrobeT strobes;

  progExcCtrl u_ctrl (
    .instValid     (instValid),
    .higherPending (higherPending),
    .instClass     (instClass),
    .strobes       (strobes)
  );

  progExcDatapath #(
    .XLEN   (XLEN),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .sprSuper    (sprSuper),
    .sprExternal (sprExternal),
    .sprValid    (sprValid),
    .trapCond    (trapCond),
    .opA         (opA),
    .opB         (opB),
    .msrPr       (msrPr),
    .msrFe0      (msrFe0),
    .msrFe1      (msrFe1),
    .msrIp       (msrIp),
    .fpsFex      (fpsFex),
    .excReq      (excReq),
    .causeBits   (causeBits),
    .excVector   (excVector),
    .fpAssistReq (fpAssistReq)
  );

endmodule

// File: rtl/progExcChecker.sv
module progExcChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [2:0]        instClass,
  input logic              higherPending,
  input logic              msrPr,
  input logic              excReq,
  input logic [2:0]        causeBits,
  input logic [ADDR_W-1:0] excVector,
  input logic              fpAssistReq
);

  // R1
  req_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excReq || fpAssistReq) |-> $past(instValid));

  // R2
  pending_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(higherPending) |-> (!excReq && !fpAssistReq));

  // R4
  arith_no_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> ($past(instClass) != 3'd7));

  // R5
  priv_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeBits[1] |-> $past(msrPr));

  // R8
  trap_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeBits[2] |-> ($past(instClass) == 3'd6));

  // R9
  vector_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (excVector[11:0] == 12'h700));

  // R9
  vector_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |-> (excVector == '0 && causeBits == 3'b000));

  // R10
  req_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (causeBits != 3'b000));

endmodule

bind progExcDetect progExcChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .instValid     (instValid),
  .instClass     (instClass),
  .higherPending (higherPending),
  .msrPr         (msrPr),
  .excReq        (excReq),
  .causeBits     (causeBits),
  .excVector     (excVector),
  .fpAssistReq   (fpAssistReq)
);

// File: tb/progExcDetect_bench.sv
module progExcDetect_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [2:0]  instClass;
  logic        sprSuper, sprExternal, sprValid;
  logic [4:0]  trapCond;
  logic [31:0] opA, opB;
  logic        msrPr, msrFe0, msrFe1, msrIp, fpsFex, higherPending;
  logic        excReq, fpAssistReq;
  logic [2:0]  causeBits;
  logic [31:0] excVector;

  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  progExcDetect u_progExcDetect (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .sprSuper(sprSuper), .sprExternal(sprExternal), .sprValid(sprValid),
    .trapCond(trapCond), .opA(opA), .opB(opB), .msrPr(msrPr),
    .msrFe0(msrFe0), .msrFe1(msrFe1), .msrIp(msrIp), .fpsFex(fpsFex),
    .higherPending(higherPending), .excReq(excReq), .causeBits(causeBits),
    .excVector(excVector), .fpAssistReq(fpAssistReq)
  );

  // Expected {excReq, fpAssistReq, causeBits, excVector} from the requirements
  function automatic logic [36:0] model();
    logic       fpCond, fire;
    logic [2:0] c;
    logic       hit;
    logic       req, assist;
    logic [31:0] vec;
    fpCond = (msrFe0 | msrFe1) & fpsFex;
    fire   = instValid & !higherPending;
    c = 3'b000;
    if (instClass == 3'd1 || instClass == 3'd2 || instClass == 3'd4) c[0] = fpCond;
    if ((instClass == 3'd2 || instClass == 3'd3 || instClass == 3'd4) && msrPr) c[1] = 1'b1;
    if (instClass == 3'd5 && sprSuper && msrPr && (sprExternal || sprValid)) c[1] = 1'b1;
    hit = (trapCond[4] && ($signed(opA) < $signed(opB))) ||
          (trapCond[3] && ($signed(opA) > $signed(opB))) ||
          (trapCond[2] && (opA == opB)) ||
          (trapCond[1] && (opA < opB)) ||
          (trapCond[0] && (opA > opB));
    if (instClass == 3'd6) c[2] = hit;
    if (!fire) c = 3'b000;
    req    = (c != 3'b000);
    assist = fire && instClass == 3'd7 && fpCond;
    vec    = req ? (msrIp ? 32'hFFF0_0700 : 32'h0000_0700) : 32'h0;
    return {req, assist, c, vec};
  endfunction

  task automatic checkVal(input string tag, input logic [36:0] got, input logic [36:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got req=%0b assist=%0b cause=%03b vec=%08h, expected req=%0b assist=%0b cause=%03b vec=%08h",
               tag, got[36], got[35], got[34:32], got[31:0], exp[36], exp[35], exp[34:32], exp[31:0]);
    end
  endtask

  task automatic clearIn();
    instValid = 1'b0; instClass = 3'd0; sprSuper = 1'b0; sprExternal = 1'b0;
    sprValid = 1'b0; trapCond = 5'd0; opA = 32'd0; opB = 32'd0; msrPr = 1'b0;
    msrFe0 = 1'b0; msrFe1 = 1'b0; msrIp = 1'b0; fpsFex = 1'b0; higherPending = 1'b0;
  endtask

  // Inputs already set at a falling edge; clock once and compare
  task automatic step(input string tag);
    logic [36:0] exp;
    exp = model();
    @(posedge clk);
    @(negedge clk);
    checkVal(tag, {excReq, fpAssistReq, causeBits, excVector}, exp);
  endtask

  task automatic trapCase(input string tag, input logic [4:0] tc, input logic [31:0] a,
                          input logic [31:0] b, input logic expHit);
    logic [36:0] exp;
    clearIn(); instValid = 1'b1; instClass = 3'd6; trapCond = tc; opA = a; opB = b;
    exp = {expHit, 1'b0, expHit, 2'b00, (expHit ? 32'h0000_0700 : 32'h0)};
    @(posedge clk);
    @(negedge clk);
    checkVal(tag, {excReq, fpAssistReq, causeBits, excVector}, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    testCount++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int unsigned seedInit;
    logic [31:0] pool [4];
    seedInit = $urandom(32'd2024);
    pool[0] = 32'h0000_0001; pool[1] = 32'h8000_0000; pool[2] = 32'hFFFF_FFFF; pool[3] = 32'h0000_0000;
    clearIn();
    rstN = 1'b0;
    instValid = 1'b1; instClass = 3'd2; msrPr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checkVal("R1 reset", {excReq, fpAssistReq, causeBits, excVector}, 37'd0);
    rstN = 1'b1;
    clearIn();

    // R1 valid low suppresses everything
    instClass = 3'd2; msrPr = 1'b1; msrFe0 = 1'b1; fpsFex = 1'b1;
    step("R1 valid low");

    // R5 privileged state move at user level
    clearIn(); instValid = 1'b1; instClass = 3'd3; msrPr = 1'b1;
    step("R5 move-from-state user");
    clearIn(); instValid = 1'b1; instClass = 3'd4; msrPr = 1'b0;
    step("R5 return supervisor");

    // R2 higher priority pending
    clearIn(); instValid = 1'b1; instClass = 3'd3; msrPr = 1'b1; higherPending = 1'b1;
    step("R2 pending");

    // R3 FP enabled on state changers, not on others
    clearIn(); instValid = 1'b1; instClass = 3'd1; msrFe1 = 1'b1; fpsFex = 1'b1;
    step("R3 move-to-FP-status");
    clearIn(); instValid = 1'b1; instClass = 3'd3; msrFe0 = 1'b1; fpsFex = 1'b1;
    step("R3 move-from-state no FP cause");

    // R4 arithmetic gives assist only
    clearIn(); instValid = 1'b1; instClass = 3'd7; msrFe0 = 1'b1; fpsFex = 1'b1; msrPr = 1'b1;
    step("R4 FP arith assist");

    // R6 / R7 special register cases
    clearIn(); instValid = 1'b1; instClass = 3'd5; sprSuper = 1'b1; msrPr = 1'b1; sprExternal = 1'b1;
    step("R6 external invalid");
    clearIn(); instValid = 1'b1; instClass = 3'd5; sprSuper = 1'b1; msrPr = 1'b1; sprValid = 1'b1;
    step("R6 internal valid");
    clearIn(); instValid = 1'b1; instClass = 3'd5; sprSuper = 1'b1; msrPr = 1'b1;
    step("R7 internal invalid");
    clearIn(); instValid = 1'b1; instClass = 3'd5; msrPr = 1'b1; sprValid = 1'b1;
    step("R7 user register");

    // R8 trap comparisons with sign-crossing operands
    trapCase("R8 signed lt", 5'b10000, 32'h8000_0000, 32'h1, 1'b1);
    trapCase("R8 unsigned lt miss", 5'b00010, 32'h8000_0000, 32'h1, 1'b0);
    trapCase("R8 unsigned gt", 5'b00001, 32'h8000_0000, 32'h1, 1'b1);
    trapCase("R8 signed gt miss", 5'b01000, 32'h8000_0000, 32'h1, 1'b0);
    trapCase("R8 equal", 5'b00100, 32'h1234, 32'h1234, 1'b1);
    trapCase("R8 no select", 5'b00000, 32'h1, 32'h2, 1'b0);

    // R9 high vector base
    clearIn(); instValid = 1'b1; instClass = 3'd2; msrPr = 1'b1; msrIp = 1'b1;
    step("R9 high base");

    // R10 coinciding causes
    clearIn(); instValid = 1'b1; instClass = 3'd4; msrPr = 1'b1; msrFe1 = 1'b1; fpsFex = 1'b1;
    step("R10 FP and privileged");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      instValid = ($urandom % 8) != 0;
      instClass = 3'($urandom);
      sprSuper = 1'($urandom); sprExternal = 1'($urandom); sprValid = 1'($urandom);
      trapCond = 5'($urandom);
      opA = pool[$urandom % 4] + 32'($urandom % 3);
      opB = pool[$urandom % 4] + 32'($urandom % 3);
      msrPr = 1'($urandom); msrFe0 = 1'($urandom); msrFe1 = 1'($urandom);
      msrIp = 1'($urandom); fpsFex = 1'($urandom);
      higherPending = ($urandom % 6) == 0;
      step("random");
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule